// File: doc/BRIEF.md
# Branch Resolution Unit

This block is the execute stage for branch operations in a 64-bit load/store pipeline. Each cycle it takes one operation code together with the decoded branch fields, the address of the current instruction, a count register, an indirect-target register and a 32-bit condition register. From these it decides whether the branch is taken, forms the next instruction address and, when asked, produces a return address for the link register and a decremented count value. Each of these results has its own valid flag.

Three branch kinds are handled. The first is an unconditional branch with a 24-bit displacement. The second is a conditional branch with a 14-bit displacement. The third is a conditional branch whose target comes from the indirect-target register. A conditional branch is taken only when two tests pass. One test compares a selected condition-register bit against an expected sense. The other checks the count register, which may also be decremented. Individual bits of a 5-bit option field turn each test on or off. All results are registered, so they appear one clock edge after the inputs are presented.

Top module: `br_resolve_unit`

## Requirements
- R1: With `op` = 1 (unconditional immediate), `next_valid` is 1 after the next clock edge.
- R2: The immediate is the displacement, sign-extended and shifted left by two bits. The unconditional form uses all 24 bits of `disp_long`. The conditional immediate form uses the 14 bits of `disp_short`.
- R3: When `abs_sel` is 1, `next_addr` is the extended immediate. When `abs_sel` is 0, `next_addr` is `cur_addr` plus the immediate, modulo 2^64.
- R4: When the branch is taken and both `link_bit` and `link_en` are 1, `link_valid` is 1 and `link_addr` is `cur_addr` + 4 modulo 2^64. In every other case `link_valid` is 0.
- R5: The condition test passes when `opt[4]` is 1, or when the selected condition bit equals `opt[3]`. Index `bit_idx` = i selects `cond_reg[31-i]`.
- R6: `cond_field` carries the 4-bit group of `cond_reg` chosen by `bit_idx[4:2]`. Group g covers bits 31-4g down to 28-4g.
- R7: On a conditional operation (`op` = 2 or 3) with `opt[2]` = 0, `count_valid` is 1 and `count_out` is `count_in` - 1 modulo 2^64, whether or not the branch is taken. When `opt[2]` = 1, or for any other `op`, `count_valid` is 0.
- R8: The count test passes when `opt[2]` is 1, or when (`count_in` != 0) XOR `opt[1]` is true. The test uses the value of `count_in` before any decrement.
- R9: A conditional operation is taken exactly when both tests pass. When it is not taken, `next_valid` and `link_valid` are 0.
- R10: A taken operation with `op` = 3 (conditional via register) gives `next_addr` = `ind_target`.
- R11: With `op` = 0 (idle), `next_valid`, `link_valid` and `count_valid` are all 0.
- R12: Every output is registered, with one cycle of latency. A synchronous active-high `rst` clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 2 | Operation: 0 idle, 1 unconditional immediate, 2 conditional immediate, 3 conditional via register |
| opt | input | 5 | Branch option bits (see R5, R7, R8) |
| bit_idx | input | 5 | Condition-register bit index |
| abs_sel | input | 1 | Immediate target is absolute rather than relative |
| link_bit | input | 1 | Instruction requests a link |
| link_en | input | 1 | Operation permits a link write |
| disp_long | input | 24 | Displacement for the unconditional form |
| disp_short | input | 14 | Displacement for the conditional immediate form |
| cur_addr | input | 64 | Address of the current instruction |
| count_in | input | 64 | Count register value |
| ind_target | input | 64 | Indirect branch target |
| cond_reg | input | 32 | Condition register |
| next_valid | output | 1 | Branch taken; `next_addr` is valid |
| next_addr | output | 64 | Next instruction address |
| link_valid | output | 1 | `link_addr` is to be written |
| link_addr | output | 64 | Return address |
| count_valid | output | 1 | `count_out` is to be written |
| count_out | output | 64 | Decremented count |
| cond_field | output | 4 | Selected condition-register group |

## Verification
Every result, including the valid flags, the addresses, the count and the condition group, is due one rising edge after the inputs are presented. Reset also takes effect on that same edge. The bench therefore changes inputs on a falling edge and reads all outputs on the following falling edge, exactly one register stage later. The properties compare each output against the inputs of the previous cycle, and they ignore any cycle whose previous edge was under reset.

// File: rtl/br_pkg.sv
package br_pkg;

  typedef enum logic [1:0] {
    BR_IDLE     = 2'd0,
    BR_JUMP     = 2'd1,
    BR_COND_IMM = 2'd2,
    BR_COND_REG = 2'd3
  } br_op_e;

  localparam int OPTW = 5;

  // option bit positions
  localparam int OPT_SKIP_COND  = 4;
  localparam int OPT_COND_SENSE = 3;
  localparam int OPT_NO_COUNT   = 2;
  localparam int OPT_ZERO_SENSE = 1;

  localparam int GRPW = 4;

endpackage

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CRW  = 32
) (
  input  logic [OPTW-1:0]          opt,
  input  logic [$clog2(CRW)-1:0]   bit_idx,
  input  logic [CRW-1:0]           cond_reg,
  input  logic [XLEN-1:0]          count_in,
  output logic                     cond_pass,
  output logic                     count_pass,
  output logic                     cnt_write,
  output logic [XLEN-1:0]          cnt_dec,
  output logic [GRPW-1:0]          field
);

  localparam int IW  = $clog2(CRW);
  localparam int NG  = CRW / GRPW;
  localparam int GW  = IW - $clog2(GRPW);

  logic [CRW-1:0]  bit_by_idx;
  logic [GRPW-1:0] grp [NG];
  logic            sel_bit;
  logic            cnt_nonzero;

  // index 0 names the most significant bit
  for (genvar i = 0; i < CRW; i++) begin : g_bits
    assign bit_by_idx[i] = cond_reg[CRW-1-i];
  end

  for (genvar g = 0; g < NG; g++) begin : g_grps
    assign grp[g] = cond_reg[CRW-1-GRPW*g -: GRPW];
  end

  logic [GW-1:0] grp_sel;
  assign grp_sel = bit_idx[IW-1 -: GW];

  assign sel_bit     = bit_by_idx[bit_idx];
  assign field       = grp[grp_sel];
  assign cnt_nonzero = |count_in;

  always_comb begin
    cond_pass  = opt[OPT_SKIP_COND] | (sel_bit == opt[OPT_COND_SENSE]);
    count_pass = opt[OPT_NO_COUNT] | (cnt_nonzero ^ opt[OPT_ZERO_SENSE]);
    cnt_write  = ~opt[OPT_NO_COUNT];
    cnt_dec    = count_in - XLEN'(1);
  end

endmodule

// File: rtl/br_target_gen.sv
module br_target_gen
  import br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int LDW  = 24,
  parameter int SDW  = 14
) (
  input  br_op_e            op,
  input  logic              abs_sel,
  input  logic [LDW-1:0]    disp_long,
  input  logic [SDW-1:0]    disp_short,
  input  logic [XLEN-1:0]   cur_addr,
  input  logic [XLEN-1:0]   ind_target,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   ret_addr
);

  localparam int LPAD = XLEN - LDW - 2;
  localparam int SPAD = XLEN - SDW - 2;

  logic [XLEN-1:0] imm_long;
  logic [XLEN-1:0] imm_short;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] rel;

  assign imm_long  = {{LPAD{disp_long[LDW-1]}}, disp_long, 2'b00};
  assign imm_short = {{SPAD{disp_short[SDW-1]}}, disp_short, 2'b00};

  always_comb begin
    imm      = (op == BR_JUMP) ? imm_long : imm_short;
    rel      = cur_addr + imm;
    ret_addr = cur_addr + XLEN'(4);
    if (op == BR_COND_REG) begin
      target = ind_target;
    end else if (abs_sel) begin
      target = imm;
    end else begin
      target = rel;
    end
  end

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
  import br_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  parameter int LDW  = 24,
  parameter int SDW  = 14
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             op,
  input  logic [4:0]             opt,
  input  logic [$clog2(CRW)-1:0] bit_idx,
  input  logic                   abs_sel,
  input  logic                   link_bit,
  input  logic                   link_en,
  input  logic [LDW-1:0]         disp_long,
  input  logic [SDW-1:0]         disp_short,
  input  logic [XLEN-1:0]        cur_addr,
  input  logic [XLEN-1:0]        count_in,
  input  logic [XLEN-1:0]        ind_target,
  input  logic [CRW-1:0]         cond_reg,
  output logic                   next_valid,
  output logic [XLEN-1:0]        next_addr,
  output logic                   link_valid,
  output logic [XLEN-1:0]        link_addr,
  output logic                   count_valid,
  output logic [XLEN-1:0]        count_out,
  output logic [3:0]             cond_field
);

  br_op_e          op_e;
  logic            cond_pass;
  logic            count_pass;
  logic            cnt_write;
  logic [XLEN-1:0] cnt_dec;
  logic [3:0]      field;
  logic [XLEN-1:0] target;
  logic [XLEN-1:0] ret_addr;
  logic            is_cond;
  logic            taken;

  assign op_e = br_op_e'(op);

  br_cond_eval #(.XLEN(XLEN), .CRW(CRW)) u_cond (
    .opt        (opt),
    .bit_idx    (bit_idx),
    .cond_reg   (cond_reg),
    .count_in   (count_in),
    .cond_pass  (cond_pass),
    .count_pass (count_pass),
    .cnt_write  (cnt_write),
    .cnt_dec    (cnt_dec),
    .field      (field)
  );

  br_target_gen #(.XLEN(XLEN), .LDW(LDW), .SDW(SDW)) u_tgt (
    .op         (op_e),
    .abs_sel    (abs_sel),
    .disp_long  (disp_long),
    .disp_short (disp_short),
    .cur_addr   (cur_addr),
    .ind_target (ind_target),
    .target     (target),
    .ret_addr   (ret_addr)
  );

  always_comb begin
    is_cond = 1'b0;
    taken   = 1'b0;
    unique case (op_e)
      BR_JUMP:     taken = 1'b1;
      BR_COND_IMM,
      BR_COND_REG: begin
        is_cond = 1'b1;
        taken   = cond_pass & count_pass;
      end
      default:     taken = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_valid  <= 1'b0;
      next_addr   <= '0;
      link_valid  <= 1'b0;
      link_addr   <= '0;
      count_valid <= 1'b0;
      count_out   <= '0;
      cond_field  <= '0;
    end else begin
      next_valid  <= taken;
      next_addr   <= target;
      link_valid  <= taken & link_bit & link_en;
      link_addr   <= ret_addr;
      count_valid <= is_cond & cnt_write;
      count_out   <= cnt_dec;
      cond_field  <= field;
    end
  end

endmodule

// File: rtl/br_resolve_checker.sv
module br_resolve_checker #(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  parameter int LDW  = 24,
  parameter int SDW  = 14
) (
  input logic                   clk,
  input logic                   rst,
  input logic [1:0]             op,
  input logic [4:0]             opt,
  input logic [$clog2(CRW)-1:0] bit_idx,
  input logic                   abs_sel,
  input logic                   link_bit,
  input logic                   link_en,
  input logic [LDW-1:0]         disp_long,
  input logic [SDW-1:0]         disp_short,
  input logic [XLEN-1:0]        cur_addr,
  input logic [XLEN-1:0]        count_in,
  input logic [XLEN-1:0]        ind_target,
  input logic [CRW-1:0]         cond_reg,
  input logic                   next_valid,
  input logic [XLEN-1:0]        next_addr,
  input logic                   link_valid,
  input logic [XLEN-1:0]        link_addr,
  input logic                   count_valid,
  input logic [XLEN-1:0]        count_out,
  input logic [3:0]             cond_field
);

  a_r1_jump_taken: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'd1) |-> next_valid);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op) == 2'd0) |-> (!next_valid && !link_valid && !count_valid));

  a_r4_link_value: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && next_valid && $past(link_bit && link_en))
      |-> (link_valid && link_addr == $past(cur_addr) + XLEN'(4)));

  a_r9_link_needs_taken: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> next_valid);

  a_r7_count_dec: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op[1] && !opt[2]))
      |-> (count_valid && count_out == $past(count_in) - XLEN'(1)));

  a_r8_zero_count_blocks: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op[1] && !opt[2] && !opt[1] && count_in == '0)) |-> !next_valid);

  a_r10_reg_target: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && next_valid && $past(op) == 2'd3) |-> next_addr == $past(ind_target));

endmodule

bind br_resolve_unit br_resolve_checker #(
  .XLEN(XLEN), .CRW(CRW), .LDW(LDW), .SDW(SDW)
) u_chk (.*);

// File: tb/sim_br_resolve_unit.sv
`timescale 1ns/1ps
module sim_br_resolve_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  op = '0;
  logic [4:0]  opt = '0;
  logic [4:0]  bit_idx = '0;
  logic        abs_sel = 1'b0;
  logic        link_bit = 1'b0;
  logic        link_en = 1'b0;
  logic [23:0] disp_long = '0;
  logic [13:0] disp_short = '0;
  logic [63:0] cur_addr = '0;
  logic [63:0] count_in = '0;
  logic [63:0] ind_target = 64'hDEAD_BEEF_0000_1230;
  logic [31:0] cond_reg = 32'h8000_0001;
  logic        next_valid, link_valid, count_valid;
  logic [63:0] next_addr, link_addr, count_out;
  logic [3:0]  cond_field;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  br_resolve_unit u0 (
    .clk(clk), .rst(rst), .op(op), .opt(opt), .bit_idx(bit_idx),
    .abs_sel(abs_sel), .link_bit(link_bit), .link_en(link_en),
    .disp_long(disp_long), .disp_short(disp_short), .cur_addr(cur_addr),
    .count_in(count_in), .ind_target(ind_target), .cond_reg(cond_reg),
    .next_valid(next_valid), .next_addr(next_addr), .link_valid(link_valid),
    .link_addr(link_addr), .count_valid(count_valid), .count_out(count_out),
    .cond_field(cond_field)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  opt;
    logic [4:0]  bidx;
    logic        aa;
    logic        lk;
    logic        lken;
    logic [23:0] disp;
    logic [63:0] cnt;
    logic        tk;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 5'b00000, 5'd0,  1'b0, 1'b1, 1'b1, 24'h000010, 64'd7, 1'b1},
    '{2'd1, 5'b00000, 5'd0,  1'b1, 1'b1, 1'b0, 24'hFFFFFF, 64'd7, 1'b1},
    '{2'd2, 5'b10100, 5'd3,  1'b0, 1'b0, 1'b0, 24'h002000, 64'd9, 1'b1},
    '{2'd2, 5'b01100, 5'd0,  1'b1, 1'b1, 1'b1, 24'h000123, 64'd9, 1'b1},
    '{2'd2, 5'b01100, 5'd1,  1'b0, 1'b1, 1'b1, 24'h000040, 64'd9, 1'b0},
    '{2'd2, 5'b00100, 5'd1,  1'b0, 1'b0, 1'b0, 24'h001FFF, 64'd9, 1'b1},
    '{2'd2, 5'b10000, 5'd8,  1'b0, 1'b0, 1'b0, 24'h000004, 64'd5, 1'b1},
    '{2'd2, 5'b10000, 5'd8,  1'b0, 1'b0, 1'b0, 24'h000004, 64'd1, 1'b1},
    '{2'd2, 5'b10000, 5'd8,  1'b0, 1'b1, 1'b1, 24'h000004, 64'd0, 1'b0},
    '{2'd2, 5'b10010, 5'd8,  1'b0, 1'b0, 1'b0, 24'h000004, 64'd0, 1'b1},
    '{2'd3, 5'b10100, 5'd4,  1'b0, 1'b1, 1'b1, 24'h000000, 64'd3, 1'b1},
    '{2'd3, 5'b01100, 5'd31, 1'b0, 1'b0, 1'b0, 24'h000000, 64'd3, 1'b1},
    '{2'd3, 5'b01100, 5'd30, 1'b0, 1'b1, 1'b1, 24'h000000, 64'd3, 1'b0},
    '{2'd0, 5'b10000, 5'd0,  1'b0, 1'b1, 1'b1, 24'h000010, 64'd3, 1'b0},
    '{2'd3, 5'b00010, 5'd0,  1'b0, 1'b1, 1'b1, 24'h000000, 64'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_imm(input vec_t v);
    logic [63:0] w;
    if (v.op == 2'd1) w = {{40{v.disp[23]}}, v.disp};
    else              w = {{50{v.disp[13]}}, v.disp[13:0]};
    return w << 2;
  endfunction

  task automatic drive(input vec_t v, input logic [63:0] ca);
    op = v.op; opt = v.opt; bit_idx = v.bidx; abs_sel = v.aa;
    link_bit = v.lk; link_en = v.lken; disp_long = v.disp;
    disp_short = v.disp[13:0]; count_in = v.cnt; cur_addr = ca;
  endtask

  task automatic run_vec(input vec_t v, input logic [63:0] ca);
    logic [63:0] ea;
    logic        elv, ecv;
    logic [3:0]  ef;
    @(negedge clk);
    drive(v, ca);
    @(negedge clk);
    // R1 R9 R11: taken flag
    chk(next_valid == v.tk, "R1/R5/R8/R9/R11 next_valid", 64'(next_valid), 64'(v.tk));
    if (v.tk) begin
      if (v.op == 2'd3) ea = ind_target;            // R10
      else if (v.aa)    ea = exp_imm(v);            // R2 R3
      else              ea = ca + exp_imm(v);       // R3
      chk(next_addr == ea, "R2/R3/R10 next_addr", next_addr, ea);
    end
    elv = v.tk && v.lk && v.lken;                   // R4
    chk(link_valid == elv, "R4 link_valid", 64'(link_valid), 64'(elv));
    if (elv) chk(link_addr == ca + 64'd4, "R4 link_addr", link_addr, ca + 64'd4);
    ecv = v.op[1] && !v.opt[2];                     // R7
    chk(count_valid == ecv, "R7 count_valid", 64'(count_valid), 64'(ecv));
    if (ecv) chk(count_out == v.cnt - 64'd1, "R7 count_out", count_out, v.cnt - 64'd1);
    ef = cond_reg[31 - 4*v.bidx[4:2] -: 4];         // R6
    chk(cond_field == ef, "R6 cond_field", 64'(cond_field), 64'(ef));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!next_valid && !link_valid && !count_valid, "R12 reset valids", 64'(next_valid), 64'd0);
    chk(next_addr == '0 && count_out == '0, "R12 reset data", next_addr, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    // R11 idle after reset
    chk(!next_valid && !count_valid, "R11 idle", 64'(next_valid), 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_vec(TBL[i], 64'h0000_1234_0000_0000 + 64'(i) * 64'h40);
    end

    // R3 R4: relative target and return address wrap at 2^64
    run_vec('{2'd1, 5'b0, 5'd0, 1'b0, 1'b1, 1'b1, 24'h000002, 64'd1, 1'b1}, 64'hFFFF_FFFF_FFFF_FFFC);
    chk(next_addr == 64'h4, "R3 wrap target", next_addr, 64'h4);
    chk(link_addr == 64'h0, "R4 wrap link", link_addr, 64'h0);

    // R2: most negative short displacement, relative
    run_vec('{2'd2, 5'b10100, 5'd0, 1'b0, 1'b0, 1'b0, 24'hFFE000, 64'd1, 1'b1}, 64'h0000_0000_0001_0000);
    chk(next_addr == 64'h0000_0000_0000_8000, "R2 min short disp", next_addr, 64'h8000);

    // R12: synchronous reset overrides a branch in the same cycle
    @(negedge clk);
    drive(TBL[0], 64'h100);
    rst = 1'b1;
    @(negedge clk);
    chk(!next_valid && next_addr == '0, "R12 reset wins", next_addr, 64'd0);
    rst = 1'b0;
    op = 2'd0;
    @(negedge clk);
    chk(!next_valid && !link_valid && !count_valid, "R11 idle after reset", 64'(next_valid), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule